// File: doc/BRIEF.md
# Debug Monitor Entry Sequencer

This block decides when a small processor core drops into its debug monitor and runs the short handshake that follows. Entry happens in one of two ways. The first is the first clock after the block reset is released. The second is a software-interrupt request while the block is idle. Both require the mode-select pins to carry the entry code and a high-voltage detect to be present on the interrupt pin or on the reset pin.

Once in monitor mode, the block counts a fixed number of security bytes that a host delivers over a byte-level receive interface, and passes them on to a separate comparator. It then holds the transmit line low for a fixed number of bit periods to tell the host that commands may follow. A single-cycle ready pulse marks the end of that break.

While monitor mode is active, the block moves the reset, software-interrupt and breakpoint vector fetches to another page. It also disables the watchdog while either high-voltage detect is present, and bypasses the clock generator while the interrupt-pin detect is present.

Top module: `monitor_entry_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle on that edge. After that edge `mon_active_o` and `ready_o` are 0, `tx_o` is 1, and the byte count and bit count are cleared.
- R2: On the first clock edge after `rst_n` rises, the block enters monitor mode (`mon_active_o` becomes 1) if `mode_sel` equals `ENTRY_CODE` (default 2'b10) and `irq_hv` or `rst_hv` is 1. If those conditions fail on that edge, the block stays idle and a later edge cannot enter without a software-interrupt request. Once set, `mon_active_o` stays 1 until reset.
- R3: While idle, a clock edge with `swi_req` high enters monitor mode under the same pin conditions as R2. The request is ignored when the conditions fail, and it is ignored when the block is already in monitor mode.
- R4: After entry, each edge with `byte_vld` high counts one security byte. `sec_vld_o` mirrors `byte_vld`, and `sec_data_o` mirrors `byte_data`, only while bytes are being counted. The edge that counts the eighth byte ends the counting phase.
- R5: `tx_o` is low from the cycle after the eighth byte is counted. It stays low until ten `bit_tick` pulses have been seen at clock edges. It is high in the cycle after the edge that sees the tenth tick. At all other times `tx_o` is high.
- R6: Bytes presented during the break, or after it, have no effect. `sec_vld_o` stays 0 and the break length does not change, so each entry forwards exactly eight bytes.
- R7: `ready_o` is high for exactly one cycle: the first cycle in which `tx_o` is high again after the break.
- R8: While `mon_active_o` is 1 and `vec_fetch` is 1, an address of 0xFFFE, 0xFFFF, 0xFFFC, 0xFFFD, 0xFFF6 or 0xFFF7 comes out on `vec_addr_o` with the upper byte 0xFE. The lower byte is unchanged. Every other case passes `vec_addr_i` through unchanged.
- R9: `wdog_dis_o` is 1 exactly when `mon_active_o` is 1 and at least one of `irq_hv` or `rst_hv` is 1.
- R10: `clk_byp_o` is 1 exactly when `mon_active_o` is 1 and `irq_hv` is 1; `rst_hv` has no effect on it. `clk_src_o` is 1 while bypassed, and otherwise equals `clk_sel_bit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release is the reset-based entry point |
| mode_sel | input | 2 | Mode-select pin levels, compared with ENTRY_CODE |
| irq_hv | input | 1 | High-voltage detect on the interrupt pin |
| rst_hv | input | 1 | High-voltage detect on the reset pin |
| swi_req | input | 1 | Software-interrupt request |
| byte_vld | input | 1 | Received-byte strobe from the serial receiver |
| byte_data | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per serial bit period |
| clk_sel_bit | input | 1 | Clock-select control bit used when not bypassed |
| vec_fetch | input | 1 | Current address is a vector fetch |
| vec_addr_i | input | 16 | Fetch address from the core |
| tx_o | output | 1 | Transmit line level |
| mon_active_o | output | 1 | Monitor mode active |
| ready_o | output | 1 | One-cycle pulse at the end of the break |
| sec_vld_o | output | 1 | Security byte strobe to the comparator |
| sec_data_o | output | 8 | Security byte to the comparator |
| wdog_dis_o | output | 1 | Watchdog disable |
| clk_byp_o | output | 1 | Clock generator bypass |
| clk_src_o | output | 1 | Selected clock source (1 = external) |
| vec_addr_o | output | 16 | Possibly remapped fetch address |

## Verification
Entry is tried in several ways: a reset release with the pins correct, a reset release with the pins wrong, a software request with the pins wrong, a software request with the pins right, and a software request while already active. Together these show that the entry conditions are sampled on the first post-reset edge only, and that the software path works from idle only. Bytes are sent with gaps and then held back to back, with extra strobes during and after the break. This shows whether the eighth byte, rather than the seventh or ninth, ends counting, and whether late strobes leak through. The vector addresses sweep the whole 0xFFF0 to 0xFFFF range and include an unrelated page, with the fetch flag toggled. The two high-voltage detects are switched separately, which pulls the watchdog-disable rule apart from the bypass rule.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_SEC = 2'd1,
        ST_SEND_BRK = 2'd2,
        ST_READY    = 2'd3
    } mon_state_e;

    typedef struct packed {
        mon_state_e st;
        logic       mon;
        logic       boot;
        logic       rdy;
    } seq_reg_t;

    // vector low bytes (even byte of each pair) that move in monitor mode
    localparam int NUM_VEC = 3;
    localparam logic [NUM_VEC*8-1:0] VEC_LO_TAB = {8'hF6, 8'hFC, 8'hFE};

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = inc && !clr && (cnt_q == TOP);

endmodule

// File: rtl/vec_remap.sv
module vec_remap
    import mon_entry_pkg::*;
#(
    parameter logic [7:0] NORM_PAGE = 8'hFF,
    parameter logic [7:0] MON_PAGE  = 8'hFE
) (
    input  logic        mon_en,
    input  logic        fetch,
    input  logic [15:0] addr_i,
    output logic [15:0] addr_o
);
    logic [NUM_VEC-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_VEC; gi++) begin : g_vec
            assign hit[gi] = (addr_i[7:1] == VEC_LO_TAB[gi*8+1 +: 7]);
        end
    endgenerate

    logic remap;
    assign remap  = mon_en && fetch && (addr_i[15:8] == NORM_PAGE) && (|hit);
    assign addr_o = {remap ? MON_PAGE : addr_i[15:8], addr_i[7:0]};

endmodule

// File: rtl/mon_pin_gate.sv
module mon_pin_gate (
    input  logic mon_en,
    input  logic irq_hv,
    input  logic rst_hv,
    input  logic clk_sel_bit,
    output logic wdog_dis,
    output logic clk_byp,
    output logic clk_src
);
    assign wdog_dis = mon_en && (irq_hv || rst_hv);
    assign clk_byp  = mon_en && irq_hv;
    assign clk_src  = clk_byp ? 1'b1 : clk_sel_bit;
endmodule

// File: rtl/monitor_entry_seq.sv
module monitor_entry_seq
    import mon_entry_pkg::*;
#(
    parameter int         NUM_SEC_BYTES = 8,
    parameter int         BRK_BITS      = 10,
    parameter logic [1:0] ENTRY_CODE    = 2'b10,
    parameter logic [7:0] NORM_PAGE     = 8'hFF,
    parameter logic [7:0] MON_PAGE      = 8'hFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_sel,
    input  logic        irq_hv,
    input  logic        rst_hv,
    input  logic        swi_req,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    input  logic        bit_tick,
    input  logic        clk_sel_bit,
    input  logic        vec_fetch,
    input  logic [15:0] vec_addr_i,
    output logic        tx_o,
    output logic        mon_active_o,
    output logic        ready_o,
    output logic        sec_vld_o,
    output logic [7:0]  sec_data_o,
    output logic        wdog_dis_o,
    output logic        clk_byp_o,
    output logic        clk_src_o,
    output logic [15:0] vec_addr_o
);
    seq_reg_t s_d, s_q;

    logic in_wait, in_brk, entry_ok, sec_last, brk_last;

    assign in_wait  = (s_q.st == ST_WAIT_SEC);
    assign in_brk   = (s_q.st == ST_SEND_BRK);
    assign entry_ok = (mode_sel == ENTRY_CODE) && (irq_hv || rst_hv);

    tick_counter #(.LIMIT(NUM_SEC_BYTES)) u_byte_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_wait),
        .inc   (in_wait && byte_vld),
        .last  (sec_last)
    );

    tick_counter #(.LIMIT(BRK_BITS)) u_bit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_brk),
        .inc   (in_brk && bit_tick),
        .last  (brk_last)
    );

    always_comb begin
        s_d      = s_q;
        s_d.boot = 1'b0;
        s_d.rdy  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (entry_ok && (s_q.boot || swi_req)) begin
                    s_d.st  = ST_WAIT_SEC;
                    s_d.mon = 1'b1;
                end
            end
            ST_WAIT_SEC: begin
                if (sec_last)
                    s_d.st = ST_SEND_BRK;
            end
            ST_SEND_BRK: begin
                if (brk_last) begin
                    s_d.st  = ST_READY;
                    s_d.rdy = 1'b1;
                end
            end
            ST_READY: begin
                s_d.st = ST_READY;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.mon  <= 1'b0;
            s_q.boot <= 1'b1;
            s_q.rdy  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_o         = !in_brk;
    assign mon_active_o = s_q.mon;
    assign ready_o      = s_q.rdy;
    assign sec_vld_o    = in_wait && byte_vld;
    assign sec_data_o   = byte_data;

    mon_pin_gate u_gate (
        .mon_en      (s_q.mon),
        .irq_hv      (irq_hv),
        .rst_hv      (rst_hv),
        .clk_sel_bit (clk_sel_bit),
        .wdog_dis    (wdog_dis_o),
        .clk_byp     (clk_byp_o),
        .clk_src     (clk_src_o)
    );

    vec_remap #(.NORM_PAGE(NORM_PAGE), .MON_PAGE(MON_PAGE)) u_remap (
        .mon_en (s_q.mon),
        .fetch  (vec_fetch),
        .addr_i (vec_addr_i),
        .addr_o (vec_addr_o)
    );

endmodule

// File: rtl/monitor_entry_chk.sv
module monitor_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_hv,
    input logic        rst_hv,
    input logic [15:0] vec_addr_i,
    input logic        tx_o,
    input logic        mon_active_o,
    input logic        ready_o,
    input logic        sec_vld_o,
    input logic        wdog_dis_o,
    input logic        clk_byp_o,
    input logic        clk_src_o,
    input logic [15:0] vec_addr_o
);
    AST_MON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mon_active_o |=> mon_active_o);                                   // R2
    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_active_o |-> tx_o);                                          // R5
    AST_NO_BYTE_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        sec_vld_o |-> (tx_o && mon_active_o && !ready_o));                // R6
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);                                            // R7
    AST_READY_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (tx_o && $past(!tx_o)));                              // R7
    AST_VEC_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr_o[7:0] == vec_addr_i[7:0]);                              // R8
    AST_VEC_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_active_o |-> (vec_addr_o == vec_addr_i));                    // R8
    AST_RSTPIN_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_active_o && rst_hv && !irq_hv) |-> (wdog_dis_o && !clk_byp_o)); // R10
    AST_BYPASS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        clk_byp_o |-> (clk_src_o && wdog_dis_o));                         // R9
endmodule

bind monitor_entry_seq monitor_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_hv       (irq_hv),
    .rst_hv       (rst_hv),
    .vec_addr_i   (vec_addr_i),
    .tx_o         (tx_o),
    .mon_active_o (mon_active_o),
    .ready_o      (ready_o),
    .sec_vld_o    (sec_vld_o),
    .wdog_dis_o   (wdog_dis_o),
    .clk_byp_o    (clk_byp_o),
    .clk_src_o    (clk_src_o),
    .vec_addr_o   (vec_addr_o)
);

// File: tb/sim_monitor_entry_seq.sv
`timescale 1ns/1ps
module sim_monitor_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        irq_hv = 1'b0, rst_hv = 1'b0, swi_req = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        bit_tick = 1'b0, clk_sel_bit = 1'b0, vec_fetch = 1'b0;
    logic [15:0] vec_addr_i = 16'h0000;
    logic        tx_o, mon_active_o, ready_o, sec_vld_o, wdog_dis_o, clk_byp_o, clk_src_o;
    logic [7:0]  sec_data_o;
    logic [15:0] vec_addr_o;

    always #2 clk = ~clk;

    monitor_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .irq_hv(irq_hv), .rst_hv(rst_hv),
        .swi_req(swi_req), .byte_vld(byte_vld), .byte_data(byte_data), .bit_tick(bit_tick),
        .clk_sel_bit(clk_sel_bit), .vec_fetch(vec_fetch), .vec_addr_i(vec_addr_i),
        .tx_o(tx_o), .mon_active_o(mon_active_o), .ready_o(ready_o), .sec_vld_o(sec_vld_o),
        .sec_data_o(sec_data_o), .wdog_dis_o(wdog_dis_o), .clk_byp_o(clk_byp_o),
        .clk_src_o(clk_src_o), .vec_addr_o(vec_addr_o)
    );

    int tests = 0, fails = 0;
    bit started = 0, done = 0, tick_en = 0;
    int cyc = 0;

    // behavioural reference: 0 idle, 1 counting, 2 break, 3 ready
    int m_st = 0, m_bytes = 0, m_bits = 0;
    bit m_mon = 0, m_boot = 1, m_rdy = 0;

    always @(posedge clk) begin
        bit ok;
        ok = (mode_sel == 2'b10) && (irq_hv || rst_hv);
        if (!rst_n) begin
            m_st = 0; m_bytes = 0; m_bits = 0; m_mon = 0; m_boot = 1; m_rdy = 0;
        end else begin
            m_rdy = 0;
            if (m_st == 0) begin
                if (ok && (m_boot || swi_req)) begin m_st = 1; m_mon = 1; m_bytes = 0; end
            end else if (m_st == 1) begin
                if (byte_vld) m_bytes++;
                if (m_bytes == 8) begin m_st = 2; m_bits = 0; end
            end else if (m_st == 2) begin
                if (bit_tick) m_bits++;
                if (m_bits == 10) begin m_st = 3; m_rdy = 1; end
            end
            m_boot = 0;
        end
        started = 1;
    end

    // stimulus for tick and vector address, just after each rising edge
    always begin
        @(posedge clk);
        #1;
        cyc++;
        bit_tick   = tick_en && (cyc % 3 == 0);
        vec_fetch  = ((cyc / 16) % 2) == 0;
        vec_addr_i = (cyc % 5 == 0) ? 16'h12FE : {8'hFF, 4'hF, 4'(cyc)};
    end

    task automatic chk(input bit good, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    int low_ticks = 0, fwd_bytes = 0;
    logic prev_tx = 1'b1;

    always @(negedge clk) begin
        if (started && !done) begin
            bit e_tx, e_sv, e_wd, e_bp, e_src, hit;
            logic [15:0] e_vec;
            e_tx  = (m_st != 2);
            e_sv  = byte_vld && (m_st == 1);
            e_wd  = m_mon && (irq_hv || rst_hv);
            e_bp  = m_mon && irq_hv;
            e_src = e_bp ? 1'b1 : clk_sel_bit;
            hit   = vec_fetch && m_mon && (vec_addr_i[15:8] == 8'hFF) &&
                    (vec_addr_i[7:1] == 7'h7F || vec_addr_i[7:1] == 7'h7E || vec_addr_i[7:1] == 7'h7B);
            e_vec = hit ? {8'hFE, vec_addr_i[7:0]} : vec_addr_i;
            chk(tx_o === e_tx, rst_n ? "R5 tx" : "R1 tx", 16'(tx_o), 16'(e_tx));
            chk(mon_active_o === m_mon, rst_n ? "R2 R3 mon" : "R1 mon", 16'(mon_active_o), 16'(m_mon));
            chk(ready_o === m_rdy, "R7 ready", 16'(ready_o), 16'(m_rdy));
            chk(sec_vld_o === e_sv, "R4 sec_vld", 16'(sec_vld_o), 16'(e_sv));
            if (e_sv) chk(sec_data_o === byte_data, "R4 sec_data", 16'(sec_data_o), 16'(byte_data));
            chk(wdog_dis_o === e_wd, "R9 wdog", 16'(wdog_dis_o), 16'(e_wd));
            chk(clk_byp_o === e_bp, "R10 bypass", 16'(clk_byp_o), 16'(e_bp));
            chk(clk_src_o === e_src, "R10 clksrc", 16'(clk_src_o), 16'(e_src));
            chk(vec_addr_o === e_vec, "R8 vector", vec_addr_o, e_vec);
            // directed: break length in ticks and bytes forwarded per entry
            if (sec_vld_o) fwd_bytes++;
            if (!tx_o && bit_tick) low_ticks++;
            if (tx_o && !prev_tx && rst_n) begin
                chk(low_ticks == 10, "R5 break ticks", 16'(low_ticks), 16'd10);
                chk(fwd_bytes == 8, "R6 bytes per entry", 16'(fwd_bytes), 16'd8);
            end
            if (!rst_n || (tx_o && !prev_tx)) begin low_ticks = 0; end
            if (!rst_n) fwd_bytes = 0;
            prev_tx = tx_o;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send_byte(input logic [7:0] d, input int gap);
        byte_data = d; byte_vld = 1'b1; step(1);
        byte_vld = 1'b0; step(gap);
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            done = 1; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick_en = 1;
        step(3);
        rst_n = 1'b1;                          // R2: wrong pins at release, stays idle
        step(3);
        swi_req = 1'b1; step(1); swi_req = 1'b0;   // R3: request without conditions ignored
        mode_sel = 2'b10; irq_hv = 1'b1; step(3);  // R2: no late entry without request
        swi_req = 1'b1; step(1); swi_req = 1'b0;   // R3: request with conditions enters
        for (int i = 0; i < 8; i++) send_byte(8'hA0 + 8'(i), 2);
        for (int i = 0; i < 4; i++) send_byte(8'h55, 3);  // R6: during break
        step(40);
        send_byte(8'h77, 1);                   // R6: after ready
        swi_req = 1'b1; step(1); swi_req = 1'b0;   // R3: ignored while active
        rst_hv = 1'b1; irq_hv = 1'b0; clk_sel_bit = 1'b0; step(4);   // R10
        clk_sel_bit = 1'b1; step(4);
        rst_hv = 1'b0; step(3);
        irq_hv = 1'b1; step(3);
        // reset-release entry with reset-pin detect only, bytes back to back
        rst_n = 1'b0; irq_hv = 1'b0; rst_hv = 1'b1; step(2);
        rst_n = 1'b1; byte_vld = 1'b1;
        for (int i = 0; i < 14; i++) begin byte_data = 8'(i * 17); step(1); end
        byte_vld = 1'b0;
        step(40);
        // reset in the middle of a break
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) send_byte(8'h3C, 0);
        step(6);
        rst_n = 1'b0; step(2);
        // release with detect absent: no entry
        rst_hv = 1'b0; rst_n = 1'b1; step(5);
        step(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule